// File: doc/BRIEF.md
# Delay-Compensated Sync Event Issuer

This block sits in every acquisition node of a cabled sensor array, in the fast clock domain. A shared calibration reference is distributed along the cable. Each node sees its rising edges late by the line and hop propagation to that node. The block detects each rising edge of the received reference and holds it back by a programmable number of fast-clock ticks, then emits a one-cycle compensated pulse. Software computes the delay for each node from the cable geometry: the hop count times the sum of the transmit and receive interface delays, plus the per-metre line delay times the cable length, taken relative to the farthest node. With that setting, every node issues its compensated pulse at the same instant as the most distant node. The pulse also serves as the calibration input of the converter clock divider.

A synchronization command strobe does not act at once. It is held as pending, and the synchronous event to the converters starts on the next compensated pulse. The event lasts one converter driving-clock period. Commands that arrive while an event is pending or running merge into that event.

Latency figures below are for the default two-stage input synchronizer. "Edge k" is the fast-clock edge at which `scc_i` is first sampled high after being sampled low.

Top module: `sei_issuer`

## Requirements
- R1: During and directly after reset, `scc_comp_o`, `sync_evt_o` and `overrun_o` are low.
- R2: With `delay_i` = 0, `scc_comp_o` is high in the cycle after edge k+2.
- R3: With `delay_i` = D > 0, `scc_comp_o` is high in the cycle after edge k+2+D.
- R4: Each compensated pulse on `scc_comp_o` is exactly one fast-clock cycle wide.
- R5: A rising reference edge that is acted on while a delay is still counting is ignored. It produces no compensated pulse, and `overrun_o` pulses high for one cycle, in the cycle after edge k+2 of that ignored edge.
- R6: The delay is captured at edge k+2. A change of `delay_i` after that edge has no effect on the pending pulse.
- R7: After a `cmd_i` strobe, `sync_evt_o` rises in the same cycle as the next compensated pulse and stays high for exactly EVT_LEN cycles (default 80).
- R8: Further `cmd_i` strobes while an event is pending or running produce no second event.
- R9: Without a pending command, compensated pulses produce no event.
- R10: A reference held high for many cycles yields a single compensated pulse, because only rising edges count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scc_i | input | 1 | Received calibration reference, asynchronous level |
| delay_i | input | 10 | Compensation delay in fast-clock ticks |
| cmd_i | input | 1 | Synchronization command strobe, one cycle |
| scc_comp_o | output | 1 | Compensated reference pulse, one cycle per accepted edge |
| sync_evt_o | output | 1 | Synchronous event to the converters, EVT_LEN cycles long |
| overrun_o | output | 1 | One-cycle pulse for each edge dropped during a count |

## Verification
On every cycle, the assertions check four things. Each compensated pulse is one cycle wide. The delay counter steps down by one while busy. An event only begins together with a compensated pulse and ends only after its full length. No command is ever pending while an event is running. Latencies under several delay values are shown only by the bench's scenarios. So are the dropped edges and the overrun pulse, delay changes made during a count, held-high levels, and the merging of repeated commands. In these scenarios a behavioural reference model predicts all three outputs cycle by cycle.

// File: rtl/sei_pkg.sv
package sei_pkg;
    localparam int unsigned DLY_W_DEF   = 10;
    localparam int unsigned EVT_LEN_DEF = 80;
    localparam int unsigned SYNC_DEF    = 2;

    typedef struct packed {
        logic pend;
        logic act;
    } evt_flags_t;
endpackage

// File: rtl/sei_edge_sync.sv
module sei_edge_sync #(
    parameter int unsigned STAGES = sei_pkg::SYNC_DEF
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lvl_i,
    output logic rise_o
);
    localparam int unsigned LEN = STAGES + 1;

    logic [LEN-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[LEN-2:0], lvl_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/sei_delay_line.sv
module sei_delay_line #(
    parameter int unsigned DLY_W = sei_pkg::DLY_W_DEF
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rise_i,
    input  logic [DLY_W-1:0] delay_i,
    output logic             fire_next_o,
    output logic             comp_o,
    output logic             ovr_o
);
    typedef struct packed {
        logic             busy;
        logic [DLY_W-1:0] cnt;
        logic             fire;
        logic             ovr;
    } dl_st_t;

    dl_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.fire = 1'b0;
        st_d.ovr  = 1'b0;
        if (st_q.busy) begin
            if (st_q.cnt == DLY_W'(1)) begin
                st_d.busy = 1'b0;
                st_d.fire = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - DLY_W'(1);
            end
            if (rise_i) st_d.ovr = 1'b1;
        end else if (rise_i) begin
            if (delay_i == '0) begin
                st_d.fire = 1'b1;
            end else begin
                st_d.busy = 1'b1;
                st_d.cnt  = delay_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign fire_next_o = st_d.fire;
    assign comp_o      = st_q.fire;
    assign ovr_o       = st_q.ovr;

    AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.busy && st_q.cnt > DLY_W'(1)) |=> (st_q.busy && st_q.cnt == $past(st_q.cnt) - DLY_W'(1))); // R3
endmodule

// File: rtl/sei_event_gen.sv
module sei_event_gen #(
    parameter int unsigned EVT_LEN = sei_pkg::EVT_LEN_DEF
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cmd_i,
    input  logic fire_i,
    output logic evt_o
);
    localparam int unsigned CW = (EVT_LEN > 1) ? $clog2(EVT_LEN) : 1;

    typedef struct packed {
        sei_pkg::evt_flags_t f;
        logic [CW-1:0]       cnt;
    } ev_st_t;

    ev_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.f.pend = st_q.f.pend | (cmd_i & ~st_q.f.act);
        if (fire_i && st_q.f.pend) begin
            st_d.f.pend = 1'b0;
            st_d.f.act  = 1'b1;
            st_d.cnt    = CW'(EVT_LEN - 1);
        end else if (st_q.f.act) begin
            if (st_q.cnt == '0) st_d.f.act = 1'b0;
            else                st_d.cnt   = st_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign evt_o = st_q.f.act;

    AST_NO_PEND_WHILE_ACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.f.act |-> !st_q.f.pend); // R8
    AST_EVT_FULL_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(st_q.f.act) |-> $past(st_q.cnt) == '0); // R7
endmodule

// File: rtl/sei_issuer.sv
module sei_issuer #(
    parameter int unsigned DLY_W   = sei_pkg::DLY_W_DEF,
    parameter int unsigned EVT_LEN = sei_pkg::EVT_LEN_DEF,
    parameter int unsigned STAGES  = sei_pkg::SYNC_DEF
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             scc_i,
    input  logic [DLY_W-1:0] delay_i,
    input  logic             cmd_i,
    output logic             scc_comp_o,
    output logic             sync_evt_o,
    output logic             overrun_o
);
    logic rise;
    logic fire_next;

    sei_edge_sync #(.STAGES(STAGES)) u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (scc_i),
        .rise_o (rise)
    );

    sei_delay_line #(.DLY_W(DLY_W)) u_dly (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .rise_i      (rise),
        .delay_i     (delay_i),
        .fire_next_o (fire_next),
        .comp_o      (scc_comp_o),
        .ovr_o       (overrun_o)
    );

    sei_event_gen #(.EVT_LEN(EVT_LEN)) u_evt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cmd_i  (cmd_i),
        .fire_i (fire_next),
        .evt_o  (sync_evt_o)
    );

    AST_COMP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        scc_comp_o |=> !scc_comp_o); // R4
    AST_EVT_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sync_evt_o) |-> scc_comp_o); // R7
endmodule

// File: tb/sei_issuer_tb.sv
module sei_issuer_tb_top;
    localparam int EVT_LEN = 80;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scc = 1'b0;
    logic [9:0] delay = '0;
    logic       cmd = 1'b0;
    logic       comp, evt, ovr;

    int    checks = 0, errors = 0, cyc = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    sei_issuer dut_i (
        .clk_i(clk), .rst_ni(rst_n), .scc_i(scc), .delay_i(delay), .cmd_i(cmd),
        .scc_comp_o(comp), .sync_evt_o(evt), .overrun_o(ovr)
    );

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // behavioural reference model
    bit h1, h2, h3, pend, exp_comp, exp_evt, exp_ovr;
    int fire_at, remain, m;
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            h1 = 0; h2 = 0; h3 = 0; pend = 0; fire_at = -1; remain = 0; m = 0;
            exp_comp = 0; exp_evt = 0; exp_ovr = 0;
        end else begin
            bit rise, fire, act_old, pend_old;
            m++;
            rise = h2 && !h3;
            exp_ovr = 0;
            if (rise) begin
                if (fire_at >= m) exp_ovr = 1;
                else fire_at = m + int'(delay);
            end
            fire = (fire_at == m);
            exp_comp = fire;
            act_old = remain > 0;
            pend_old = pend;
            if (remain > 0) remain--;
            pend = pend | (cmd && !act_old);
            if (fire && pend_old) begin remain = EVT_LEN; pend = 0; end
            exp_evt = remain > 0;
            h3 = h2; h2 = h1; h1 = scc;
        end
    end

    // per-cycle comparison and counters
    int comp_cnt = 0, ovr_cnt = 0, evt_starts = 0, evt_w = 0;
    bit evt_prev = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            check(cur_req, comp, exp_comp, "scc_comp_o vs model");
            check(cur_req, evt, exp_evt, "sync_evt_o vs model");
            check(cur_req, ovr, exp_ovr, "overrun_o vs model");
            comp_cnt += int'(comp);
            ovr_cnt  += int'(ovr);
            if (evt && !evt_prev) begin
                evt_starts++;
                evt_w = 0;
                check("R7", comp, 1, "event start aligned to compensated pulse");
            end
            if (evt) evt_w++;
            if (!evt && evt_prev) check("R7", evt_w, EVT_LEN, "event width");
            evt_prev = evt;
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(int hi, int lo);
        scc = 1'b1; idle(hi); scc = 1'b0; idle(lo);
    endtask

    task automatic strobe_cmd();
        cmd = 1'b1; idle(1); cmd = 1'b0;
    endtask

    task automatic latency(string req, int d);
        delay = 10'(d);
        scc = 1'b1;
        idle(2 + d);
        check(req, comp, 0, "no pulse before latency");
        idle(1);
        check(req, comp, 1, "pulse at latency 2+D");
        idle(1);
        check("R4", comp, 0, "pulse is one cycle");
        idle(3);
        scc = 1'b0;
        idle(6);
    endtask

    initial begin
        int c0, o0, e0;
        idle(4);
        check("R1", comp, 0, "comp in reset");
        check("R1", evt, 0, "evt in reset");
        check("R1", ovr, 0, "ovr in reset");
        rst_n = 1'b1;
        idle(1);
        check("R1", comp + evt + ovr, 0, "outputs after reset");
        idle(4);

        cur_req = "R2"; latency("R2", 0);
        cur_req = "R3"; latency("R3", 37); latency("R3", 1);

        cur_req = "R10"; delay = 10'd2; c0 = comp_cnt;
        pulse(60, 10);
        check("R10", comp_cnt - c0, 1, "held level gives one pulse");

        cur_req = "R6"; delay = 10'd20; scc = 1'b1;
        idle(3); delay = 10'd3;
        idle(19); check("R6", comp, 0, "late delay change ignored, early");
        idle(1);  check("R6", comp, 1, "late delay change ignored, pulse");
        scc = 1'b0; idle(10);

        cur_req = "R5"; delay = 10'd50; c0 = comp_cnt; o0 = ovr_cnt;
        pulse(4, 10); pulse(4, 80);
        check("R5", comp_cnt - c0, 1, "edge during count dropped");
        check("R5", ovr_cnt - o0, 1, "overrun pulse count");

        cur_req = "R7"; delay = 10'd5; e0 = evt_starts;
        strobe_cmd(); idle(5);
        pulse(4, 100);
        check("R7", evt_starts - e0, 1, "one event after command");

        cur_req = "R8"; delay = 10'd4; e0 = evt_starts;
        strobe_cmd(); idle(3); strobe_cmd(); idle(3);
        pulse(4, 20);
        strobe_cmd(); idle(80);
        pulse(4, 30);
        check("R8", evt_starts - e0, 1, "merged commands give one event");

        cur_req = "R9"; e0 = evt_starts; c0 = comp_cnt;
        pulse(4, 20); pulse(4, 20);
        check("R9", evt_starts - e0, 0, "no event without command");
        check("R9", comp_cnt - c0, 2, "pulses still issued");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule